// File: doc/BRIEF.md
# Prescaled One-Shot / Periodic Down-Counter

The block is a 32-bit down-counting timer. A free-running prescaler turns the core clock into a tick stream. The tick rate is one tick every 1, 2, 4 … 128 clocks, and a 3-bit divide code picks the rate. On each tick the count drops by one.

A control entry sets three things: one-shot or periodic operation, whether expiry events are masked, and the 8-bit vector that goes out with each event. In one-shot mode the counter runs down to zero, stays there, and raises a single event. In periodic mode it reloads after zero, so every period is the initial count plus one ticks long.

Software writes the initial count, the divide code and the control entry through three write strobes that share one data bus. It reads the running value on `count_o`. An expiry event is a one-clock strobe on `irq_o`, with the vector on `irq_vector_o` in the same cycle. Every event is an edge event; no level state is held for the receiver.

Top module: `prescaled_timer`

## Requirements
- R1: After reset, `count_o` is 0, `irq_o` is 0, the control entry reads as masked one-shot with vector 0, and the divide code is 000, which divides by 2.
- R2: A divide write keeps data bits 3, 1 and 0. The code is v = {bit3, bit1, bit0}, the shift is (v+1) mod 8, and the tick period is 2^shift clocks. So code 111 (data 0xB) divides by 1 and code 000 divides by 2. The prescaler is free-running and is never cleared by a write.
- R3: A count write loads `wdata_i` into the counter and the reload register, and `count_o` shows it on the next cycle. It wins over a tick in the same cycle.
- R4: In one-shot mode (entry bit 17 = 0) each tick lowers the count by one until it reaches 0, and the count then stays at 0. On the first tick that finds the count at 0 the timer expires once.
- R5: In periodic mode (entry bit 17 = 1) a tick that finds the count at 0 reloads the initial count and raises an event. Successive events are therefore (N+1)·2^shift clocks apart.
- R6: While entry bit 16 (mask) is 1, no event reaches `irq_o`, and the counter keeps running.
- R7: Each expiry raises `irq_o` for one clock, in the cycle after the expiring tick. `irq_vector_o` carries entry bits 7:0 in that cycle.
- R8: An initial count of 0 leaves a one-shot timer idle with no event. In periodic mode a count of 0 raises an event on every tick.
- R9: A control entry write changes mode, mask and vector from the next tick on, and does not reload or restart the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_count_i | input | 1 | Write strobe for the initial count |
| wr_div_i | input | 1 | Write strobe for the divide code |
| wr_entry_i | input | 1 | Write strobe for the control entry |
| wdata_i | input | 32 | Write data shared by all three strobes |
| count_o | output | 32 | Current count |
| irq_o | output | 1 | One-clock expiry strobe |
| irq_vector_o | output | 8 | Vector that goes with `irq_o` |

## Verification
The prescaler phase is the hard part to control. It is never cleared, so the position of the first tick after a count write depends on every cycle since reset. The bench handles this in two ways. It runs a cycle-accurate model that counts clocks from reset and compares it against the block every cycle. It also uses intervals between events, which do not depend on phase, for arithmetic checks over all eight divide codes, both modes and several counts. Mode and mask changes are applied in the middle of a running count, so the no-reload rule is tested while the counter is away from its loaded value.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int CNT_W   = 32;
  localparam int VEC_W   = 8;
  localparam int SHIFT_W = 3;
  localparam int DIV_W   = 4;

  localparam int ENT_PERIODIC_BIT = 17;
  localparam int ENT_MASK_BIT     = 16;

  typedef struct packed {
    logic             periodic;
    logic             mask;
    logic [VEC_W-1:0] vector;
  } entry_t;

  localparam entry_t ENTRY_RESET = '{periodic: 1'b0, mask: 1'b1, vector: '0};

  // divide code: bits {3,1,0} form v, shift = v + 1 (mod 8)
  function automatic logic [SHIFT_W-1:0] div_to_shift(input logic [DIV_W-1:0] code);
    logic [SHIFT_W-1:0] v;
    v = {code[3], code[1:0]};
    return v + SHIFT_W'(1);
  endfunction
endpackage

// File: rtl/timer_cfg.sv
module timer_cfg
  import timer_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_div_i,
  input  logic              wr_entry_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [SHIFT_W-1:0] shift_o,
  output entry_t            entry_o
);
  localparam logic [DIV_W-1:0] DIV_KEEP = 4'b1011;

  logic [DIV_W-1:0] div_q;
  entry_t           entry_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q   <= '0;
      entry_q <= ENTRY_RESET;
    end else begin
      if (wr_div_i)   div_q <= wdata_i[DIV_W-1:0] & DIV_KEEP;
      if (wr_entry_i) begin
        entry_q.periodic <= wdata_i[ENT_PERIODIC_BIT];
        entry_q.mask     <= wdata_i[ENT_MASK_BIT];
        entry_q.vector   <= wdata_i[VEC_W-1:0];
      end
    end
  end

  assign shift_o = div_to_shift(div_q);
  assign entry_o = entry_q;

  assert_entry_wr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_entry_i |=> (entry_o.mask == $past(wdata_i[ENT_MASK_BIT])));
endmodule

// File: rtl/timer_prescaler.sv
module timer_prescaler #(
  parameter int SHIFT_W = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [SHIFT_W-1:0] shift_i,
  output logic               tick_o
);
  localparam int PRE_W = (1 << SHIFT_W) - 1;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] sel_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pre_q <= '0;
    else         pre_q <= pre_q + PRE_W'(1);
  end

  for (genvar i = 0; i < PRE_W; i++) begin : g_sel
    assign sel_w[i] = (SHIFT_W'(i) < shift_i);
  end

  // tick when the selected low bits of the free-running counter are all ones
  assign tick_o = &(pre_q | ~sel_w);

  assert_spacing_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && shift_i != '0) |=> (!tick_o || shift_i != $past(shift_i)));
endmodule

// File: rtl/timer_core.sv
module timer_core
  import timer_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  entry_t           entry_i,
  output logic [CNT_W-1:0] count_o,
  output logic             irq_o,
  output logic [VEC_W-1:0] irq_vector_o
);
  logic [CNT_W-1:0] count_q, reload_q;
  logic             armed_q, irq_q;
  logic [VEC_W-1:0] vec_q;
  logic             at_zero, expire;

  assign at_zero = (count_q == '0);
  assign expire  = tick_i && !load_i && at_zero && (entry_i.periodic || armed_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q  <= '0;
      reload_q <= '0;
      armed_q  <= 1'b0;
    end else if (load_i) begin
      count_q  <= load_val_i;
      reload_q <= load_val_i;
      armed_q  <= (load_val_i != '0);
    end else if (tick_i) begin
      if (!at_zero)              count_q <= count_q - CNT_W'(1);
      else if (entry_i.periodic) count_q <= reload_q;
      else                       armed_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
      vec_q <= '0;
    end else begin
      irq_q <= expire && !entry_i.mask;
      if (expire) vec_q <= entry_i.vector;
    end
  end

  assign count_o      = count_q;
  assign irq_o        = irq_q;
  assign irq_vector_o = vec_q;

  assert_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (count_q == $past(load_val_i)));
  assert_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_i && !at_zero) |=> (count_q == $past(count_q) - CNT_W'(1)));
  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !load_i) |=> $stable(count_q));
  assert_oneshot_stay_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_i && at_zero && !entry_i.periodic) |=> (count_q == '0 && !armed_q));
endmodule

// File: rtl/prescaled_timer.sv
module prescaled_timer
  import timer_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_count_i,
  input  logic              wr_div_i,
  input  logic              wr_entry_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [CNT_W-1:0]  count_o,
  output logic              irq_o,
  output logic [VEC_W-1:0]  irq_vector_o
);
  logic [SHIFT_W-1:0] shift_w;
  entry_t             entry_w;
  logic               tick_w;

  timer_cfg #(.DATA_W(DATA_W)) i_cfg (
    .clk_i, .rst_ni, .wr_div_i, .wr_entry_i, .wdata_i,
    .shift_o(shift_w), .entry_o(entry_w)
  );

  timer_prescaler #(.SHIFT_W(SHIFT_W)) i_pre (
    .clk_i, .rst_ni, .shift_i(shift_w), .tick_o(tick_w)
  );

  timer_core i_core (
    .clk_i, .rst_ni,
    .tick_i(tick_w), .load_i(wr_count_i), .load_val_i(wdata_i[CNT_W-1:0]),
    .entry_i(entry_w),
    .count_o, .irq_o, .irq_vector_o
  );

  assert_mask_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> !$past(entry_w.mask));
  assert_vector_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (irq_vector_o == $past(entry_w.vector)));
endmodule

// File: tb/test_prescaled_timer.sv
module test_prescaled_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_count = 1'b0, wr_div = 1'b0, wr_entry = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] count_o;
  logic        irq_o;
  logic [7:0]  irq_vector_o;

  int errors = 0, checks = 0;
  longint cyc = 0;

  always #2.5 clk = ~clk;

  prescaled_timer i_prescaled_timer (
    .clk_i(clk), .rst_ni(rst_n), .wr_count_i(wr_count), .wr_div_i(wr_div),
    .wr_entry_i(wr_entry), .wdata_i(wdata), .count_o(count_o), .irq_o(irq_o),
    .irq_vector_o(irq_vector_o)
  );

  // reference model built from the requirements
  int          m_pre, m_shift;
  bit          m_per, m_mask, m_arm, m_irq, m_tick, m_fire;
  logic [7:0]  m_vec, m_ivec;
  logic [31:0] m_cnt, m_rel;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pre = 0; m_shift = 1; m_per = 0; m_mask = 1; m_vec = 0;
      m_cnt = 0; m_rel = 0; m_arm = 0; m_irq = 0; m_ivec = 0;
    end else begin
      m_tick = ((m_pre + 1) % (1 << m_shift)) == 0;
      m_pre  = (m_pre + 1) % 128;
      m_fire = m_tick && !wr_count && m_cnt == 0 && (m_per || m_arm);
      m_irq  = m_fire && !m_mask;
      if (m_fire) m_ivec = m_vec;
      if (wr_count) begin
        m_cnt = wdata; m_rel = wdata; m_arm = (wdata != 0);
      end else if (m_tick) begin
        if (m_cnt != 0) m_cnt = m_cnt - 1;
        else if (m_per) m_cnt = m_rel;
        else m_arm = 0;
      end
      if (wr_div) m_shift = ({wdata[3], wdata[1:0]} + 1) % 8;
      if (wr_entry) begin
        m_per = wdata[17]; m_mask = wdata[16]; m_vec = wdata[7:0];
      end
    end
  end

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rst_n) begin
      checks++;
      if (count_o !== m_cnt || irq_o !== m_irq || (m_irq && irq_vector_o !== m_ivec)) begin
        errors++;
        $display("FAIL R4/R5 model cyc %0d: count=%0d irq=%0b vec=%0h expected count=%0d irq=%0b vec=%0h",
                 cyc, count_o, irq_o, irq_vector_o, m_cnt, m_irq, m_ivec);
      end
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int kind, input logic [31:0] d);
    wdata = d;
    wr_count = (kind == 0); wr_div = (kind == 1); wr_entry = (kind == 2);
    @(negedge clk);
    wr_count = 0; wr_div = 0; wr_entry = 0;
  endtask

  function automatic logic [31:0] ent(input bit per, input bit msk, input logic [7:0] v);
    return (32'(per) << 17) | (32'(msk) << 16) | 32'(v);
  endfunction

  function automatic logic [31:0] divw(input int code);
    return {28'b0, code[2], 1'b0, code[1:0]};
  endfunction

  int     n_irq, bad_iv, bad_vec;
  longint last_t;

  task automatic window(input int len, input longint exp_iv, input logic [7:0] vec);
    n_irq = 0; bad_iv = 0; bad_vec = 0; last_t = -1;
    for (int k = 0; k < len; k++) begin
      if (irq_o) begin
        if (last_t >= 0 && exp_iv > 0 && (cyc - last_t) != exp_iv) bad_iv++;
        if (irq_vector_o !== vec) bad_vec++;
        last_t = cyc; n_irq++;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    fork
      begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(count_o == 0, "R1 count", count_o, 0);
        chk(irq_o == 0, "R1 irq", irq_o, 0);
        // reset entry is masked one-shot; default divide is 2
        wr(0, 3);
        window(20, 0, 8'h00);
        chk(n_irq == 0, "R1 masked after reset", n_irq, 0);
        wr(2, ent(1, 0, 8'h21));
        wr(0, 2);
        window(40, 6, 8'h21);
        chk(bad_iv == 0 && n_irq >= 3, "R1 default divide by 2 (R2)", bad_iv, 0);

        // sweep divide codes, modes and counts
        for (int code = 0; code < 8; code++) begin
          for (int per = 0; per < 2; per++) begin
            for (int ni = 0; ni < 3; ni++) begin
              int n, d;
              logic [7:0] v;
              n = (ni == 0) ? 0 : (ni == 1) ? 1 : 3;
              d = 1 << ((code + 1) % 8);
              v = 8'(8'h40 + code * 8 + per * 4 + ni);
              wr(1, divw(code));
              wr(2, ent(per[0], 0, v));
              wr(0, 32'(n));
              window((n + 1) * d * 4 + 4, longint'((n + 1) * d), v);
              chk(bad_vec == 0, "R7 vector", bad_vec, 0);
              if (per == 1) begin
                chk(bad_iv == 0, "R5 period (N+1)*D", bad_iv, 0);
                chk(n_irq >= 3, "R5 events per window", n_irq, 3);
                if (n == 0) chk(n_irq >= 3, "R8 periodic zero", n_irq, 3);
              end else begin
                chk(n_irq == (n != 0), (n == 0) ? "R8 one-shot zero idle" : "R4 single event",
                    n_irq, (n != 0));
                chk(count_o == 0, "R4 hold at zero", count_o, 0);
              end
            end
          end
        end

        // R3: load wins and shows next cycle with divide by 1
        wr(1, 32'hB);
        wr(0, 10);
        chk(count_o == 10, "R3 load visible", count_o, 10);
        @(negedge clk);
        chk(count_o == 9, "R2 divide by 1", count_o, 9);

        // R6: mask suppresses events, counter keeps running
        wr(2, ent(1, 1, 8'h5A));
        wr(0, 2);
        window(30, 0, 8'h5A);
        chk(n_irq == 0, "R6 masked", n_irq, 0);
        begin
          logic [31:0] c0;
          c0 = count_o; @(negedge clk);
          chk(count_o != c0, "R6 counter runs while masked", count_o, c0);
        end
        // R9: unmask mid-run, no reload
        wr(0, 50);
        repeat (10) @(negedge clk);
        begin
          logic [31:0] c1;
          c1 = count_o;
          wr(2, ent(1, 0, 8'h5B));
          chk(count_o == c1 - 1, "R9 no reload on entry write", count_o, c1 - 1);
        end
        window(200, 51, 8'h5B);
        chk(n_irq >= 3 && bad_iv == 0, "R9 unmask takes effect", n_irq, 3);
        // R9: switch to one-shot mid-run
        wr(2, ent(0, 0, 8'h5C));
        window(120, 0, 8'h5C);
        chk(n_irq <= 1, "R9 one-shot after switch", n_irq, 1);
        chk(count_o == 0, "R9 stays at zero", count_o, 0);
        // R2: only bits 3,1,0 kept: 0xF behaves as 0xB (divide by 1)
        wr(1, 32'hF);
        wr(2, ent(1, 0, 8'h11));
        wr(0, 4);
        window(40, 5, 8'h11);
        chk(bad_iv == 0 && n_irq >= 3, "R2 bit 2 ignored", bad_iv, 0);
      end
      begin
        repeat (190000) @(negedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule